// File: doc/BRIEF.md
# DPLL mode and lock controller

This block is the control state machine that sits beside a digital phase-locked loop. It decides whether the loop runs unlocked from the local master clock (freerun) or tracks the incoming reference (normal), it gates the clock outputs during a timed start-up hold after the reset pin is released, and it drives a lock indicator derived from the phase-detector error.

All timing is counted in master-clock cycles. The start-up hold, the lock qualifying time, the lock hold-off after a fall to freerun and the phase-lock window are parameters. The defaults are a 3 ms hold (75,000 cycles), a 10 ms qualifying time (250,000 cycles) and a 0.1 s hold-off (2,500,000 cycles) at 25 MHz. The phase error is a signed two's complement sample taken on every clock edge. It has no handshake, because the phase detector produces a new value every cycle and cannot be stalled. The reference-fail flag is a plain level.

Top module: `dpll_mode_lock_ctl`

## Requirements
- R1: While `rst_ni` is low, `mode_o` is 2'b00 (reset hold), `out_en_o` is 0 and `lock_o` is 0, without waiting for a clock edge.
- R2: After `rst_ni` goes high, `out_en_o` stays 0 for the first RESET_CYC-1 rising edges. At the RESET_CYC-th edge it rises and `mode_o` becomes 2'b01 (freerun). `ref_fail_i` has no effect during the hold.
- R3: In freerun, a rising edge that samples `ref_fail_i` = 0 moves `mode_o` to 2'b10 (normal).
- R4: In normal, a rising edge that samples `ref_fail_i` = 1 moves `mode_o` to 2'b01. The mode stays at 2'b01 for as long as `ref_fail_i` stays 1.
- R5: The phase error `phase_err_i` is in the window when -WINDOW <= phase_err_i <= WINDOW, read as signed two's complement. Any value outside that range never qualifies.
- R6: `lock_o` rises after QUAL_CYC consecutive rising edges that each see normal mode, `ref_fail_i` = 0 and an in-window phase error. It is still 0 after QUAL_CYC-1 such edges.
- R7: An edge with the phase error outside the window during qualification restarts the count from zero.
- R8: `lock_o` is never asserted during freerun entered from start-up, whatever the phase error.
- R9: After a fall from normal to freerun with `lock_o` high, `lock_o` stays high for HOLD_CYC-1 further edges in freerun and drops at the HOLD_CYC-th.
- R10: If normal mode is regained before the hold-off expires, `lock_o` stays high without requalifying. A later fall to freerun restarts the full hold-off.
- R11: Once `lock_o` is high in normal mode, excursions of the phase error do not clear it.
- R12: Taking `rst_ni` low at any time clears the mode, the output enable and the lock, and a new start-up hold follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset pin |
| ref_fail_i | input | 1 | Reference failure level from the reference monitors |
| phase_err_i | input | PE_W | Signed phase-detector error, one sample per cycle |
| mode_o | output | 2 | 00 reset hold, 01 freerun, 10 normal |
| out_en_o | output | 1 | Clock output enable, 0 during reset and the start-up hold |
| lock_o | output | 1 | Lock indicator |

## Verification
A wrong mode state appears on `mode_o` and `out_en_o` one edge after the `ref_fail_i` level that should have moved it. The bench compares the mode after every edge around each transition. A qualifying counter that is off by one, or that fails to restart, shows on `lock_o` exactly at edge QUAL_CYC or QUAL_CYC-1 of a run. The bench sweeps every excursion position and every phase value around both window edges. A faulty hold-off counter shows at the HOLD_CYC-th freerun edge. So does a fault that makes lock requalify on recovery, because recovery is tested with the phase error held outside the window at each possible recovery point.

// File: rtl/dpll_ctl_pkg.sv
package dpll_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_RST  = 2'b00,
    MODE_FREE = 2'b01,
    MODE_NORM = 2'b10
  } loop_mode_e;

endpackage

// File: rtl/dpll_start_hold.sv
// Counts master-clock edges after reset release; flags the last hold edge.
module dpll_start_hold #(
  parameter int RESET_CYC = 75000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);
  localparam int CW = $clog2(RESET_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RESET_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign last_o = !done_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_last_i,
  input  logic       ref_fail_i,
  output loop_mode_e mode_o
);
  loop_mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_RST:  if (hold_last_i) state_d = MODE_FREE;
      MODE_FREE: if (!ref_fail_i) state_d = MODE_NORM;
      MODE_NORM: if (ref_fail_i)  state_d = MODE_FREE;
      default:   state_d = MODE_RST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MODE_RST;
    else         state_q <= state_d;
  end

  assign mode_o = state_q;

  // R2
  no_rst_to_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_RST) |=> (state_q != MODE_NORM));

  // R3
  free_to_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_FREE && !ref_fail_i) |=> (state_q == MODE_NORM));

  // R4
  norm_to_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_NORM && ref_fail_i) |=> (state_q == MODE_FREE));

  // R4
  free_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_FREE && ref_fail_i) |=> (state_q == MODE_FREE));
endmodule

// File: rtl/dpll_phase_qual.sv
// Counts consecutive in-window samples while the loop tracks a healthy reference.
module dpll_phase_qual #(
  parameter int PE_W     = 16,
  parameter int WINDOW   = 64,
  parameter int QUAL_CYC = 250000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [PE_W-1:0] phase_err_i,
  output logic                   hit_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYC - 1);

  logic          inwin;
  logic [QW-1:0] streak_q;

  generate
    if (WINDOW == 0) begin : g_exact
      assign inwin = (phase_err_i == '0);
    end else begin : g_range
      localparam logic signed [PE_W-1:0] WIN_POS = PE_W'(WINDOW);
      localparam logic signed [PE_W-1:0] WIN_NEG = -WIN_POS;
      assign inwin = (phase_err_i <= WIN_POS) && (phase_err_i >= WIN_NEG);
    end
  endgenerate

  assign hit_o = en_i && inwin && (streak_q == QLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      streak_q <= '0;
    end else if (en_i && inwin) begin
      if (streak_q != QLAST) streak_q <= streak_q + 1'b1;
    end else begin
      streak_q <= '0;
    end
  end

  // R7
  streak_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    streak_q <= QLAST);

  // R6
  hit_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> en_i);
endmodule

// File: rtl/dpll_lock_hold.sv
module dpll_lock_hold
  import dpll_ctl_pkg::*;
#(
  parameter int HOLD_CYC = 2500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  loop_mode_e mode_i,
  input  logic       qual_hit_i,
  output logic       lock_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

  logic          lock_q;
  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      hcnt_q <= '0;
    end else if (mode_i == MODE_FREE && lock_q) begin
      if (hcnt_q == HLAST) begin
        lock_q <= 1'b0;
        hcnt_q <= '0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end else begin
      hcnt_q <= '0;
      if (qual_hit_i) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;

  // R6
  lock_rise_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> (mode_i == MODE_NORM));

  // R9
  lock_fall_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> ($past(mode_i) == MODE_FREE));

  // R8
  no_lock_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RST) |-> !lock_q);

  // R9
  hcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= HLAST);
endmodule

// File: rtl/dpll_mode_lock_ctl.sv
module dpll_mode_lock_ctl
  import dpll_ctl_pkg::*;
#(
  parameter int PE_W      = 16,
  parameter int WINDOW    = 64,
  parameter int RESET_CYC = 75000,
  parameter int QUAL_CYC  = 250000,
  parameter int HOLD_CYC  = 2500000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ref_fail_i,
  input  logic signed [PE_W-1:0] phase_err_i,
  output logic [1:0]             mode_o,
  output logic                   out_en_o,
  output logic                   lock_o
);
  loop_mode_e mode;
  logic       hold_last;
  logic       qual_en;
  logic       qual_hit;

  dpll_start_hold #(.RESET_CYC(RESET_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_o (hold_last)
  );

  dpll_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_last_i (hold_last),
    .ref_fail_i  (ref_fail_i),
    .mode_o      (mode)
  );

  assign qual_en = (mode == MODE_NORM) && !ref_fail_i;

  dpll_phase_qual #(.PE_W(PE_W), .WINDOW(WINDOW), .QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (qual_en),
    .phase_err_i (phase_err_i),
    .hit_o       (qual_hit)
  );

  dpll_lock_hold #(.HOLD_CYC(HOLD_CYC)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .qual_hit_i (qual_hit),
    .lock_o     (lock_o)
  );

  assign mode_o   = mode;
  assign out_en_o = (mode != MODE_RST);
endmodule

// File: tb/sim_dpll_mode_lock_ctl.sv
module sim_dpll_mode_lock_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 6;
  localparam int WIN = 3;
  localparam int RC = 5;
  localparam int QC = 4;
  localparam int HC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_fail = 1'b1;
  logic signed [PW-1:0] pe = '0;
  logic [1:0] mode;
  logic out_en, lock;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_mode_lock_ctl #(.PE_W(PW), .WINDOW(WIN), .RESET_CYC(RC),
                       .QUAL_CYC(QC), .HOLD_CYC(HC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_fail_i(ref_fail), .phase_err_i(pe),
    .mode_o(mode), .out_en_o(out_en), .lock_o(lock)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (RC) @(negedge clk);
  endtask

  task automatic get_locked();
    do_reset();
    ref_fail = 1'b0; pe = '0;
    repeat (1 + QC) @(negedge clk);
  endtask

  initial begin
    // R1: state while reset is held
    @(negedge clk);
    chk("R1", "mode in reset", int'(mode), 0);
    chk("R1", "out_en in reset", int'(out_en), 0);
    chk("R1", "lock in reset", int'(lock), 0);

    // R2: hold length, ref_fail ignored during hold
    ref_fail = 1'b0; rst_n = 1'b1;
    for (int k = 1; k <= RC; k++) begin
      @(negedge clk);
      chk("R2", "out_en during hold", int'(out_en), (k == RC) ? 1 : 0);
      chk("R2", "mode during hold", int'(mode), (k == RC) ? 1 : 0);
    end
    // R3: freerun to normal
    @(negedge clk);
    chk("R3", "mode after healthy ref", int'(mode), 2);

    // R5 R6: sweep the phase error around both window edges
    for (int v = -(WIN + 2); v <= WIN + 2; v++) begin
      do_reset();
      ref_fail = 1'b0; pe = PW'(v);
      @(negedge clk);
      repeat (QC - 1) @(negedge clk);
      chk("R6", "lock one edge early", int'(lock), 0);
      @(negedge clk);
      chk("R5", "lock vs window", int'(lock), (v >= -WIN && v <= WIN) ? 1 : 0);
    end

    // R7: excursion at every position restarts qualification
    for (int j = 0; j < QC; j++) begin
      do_reset();
      ref_fail = 1'b0; pe = '0;
      @(negedge clk);
      repeat (j) @(negedge clk);
      pe = PW'(WIN + 1);
      @(negedge clk);
      pe = '0;
      repeat (QC - 1) @(negedge clk);
      chk("R7", "lock after restart short", int'(lock), 0);
      @(negedge clk);
      chk("R7", "lock after full restart", int'(lock), 1);
    end

    // R8 R4: startup freerun never locks, mode stays freerun
    do_reset();
    ref_fail = 1'b1; pe = '0;
    for (int k = 0; k < 3 * QC; k++) begin
      @(negedge clk);
      chk("R8", "lock in startup freerun", int'(lock), 0);
      chk("R4", "mode held freerun", int'(mode), 1);
    end

    // R9 R4: hold-off length after a fall to freerun
    get_locked();
    ref_fail = 1'b1;
    @(negedge clk);
    chk("R4", "mode after failure", int'(mode), 1);
    chk("R9", "lock at freerun entry", int'(lock), 1);
    for (int k = 1; k <= HC; k++) begin
      @(negedge clk);
      chk("R9", "lock during hold-off", int'(lock), (k < HC) ? 1 : 0);
    end

    // R10 R11: recovery at every point inside the hold-off
    for (int m = 0; m <= HC - 2; m++) begin
      get_locked();
      ref_fail = 1'b1;
      @(negedge clk);
      repeat (m) @(negedge clk);
      ref_fail = 1'b0; pe = PW'(-30);
      @(negedge clk);
      chk("R10", "mode after recovery", int'(mode), 2);
      chk("R10", "lock kept on recovery", int'(lock), 1);
      repeat (2 * QC) @(negedge clk);
      chk("R11", "lock with phase outside", int'(lock), 1);
      ref_fail = 1'b1;
      @(negedge clk);
      repeat (HC - 1) @(negedge clk);
      chk("R10", "full hold-off restarted", int'(lock), 1);
      @(negedge clk);
      chk("R10", "lock drop after restart", int'(lock), 0);
    end

    // R12: reset in the middle of operation
    get_locked();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12", "mode on mid reset", int'(mode), 0);
    chk("R12", "out_en on mid reset", int'(out_en), 0);
    chk("R12", "lock on mid reset", int'(lock), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (RC - 1) @(negedge clk);
    chk("R12", "new hold running", int'(out_en), 0);
    @(negedge clk);
    chk("R12", "new hold ends", int'(out_en), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule